// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Engine

This unit scores how closely a candidate block of samples matches a reference block: the score is the sum, over all 64 positions of an 8x8 block, of the absolute difference between the reference sample and the candidate sample at that position. A motion-search controller streams both blocks in, one row at a time. Each transfer carries eight reference samples and the eight candidate samples at the same positions. The controller gets back one score for each block, together with a tag that it supplied with the block's first row.

The unit has no absolute-value stage. Each lane splits its signed difference into two non-negative parts. One part holds the amount by which the reference exceeds the candidate, and the other holds the amount by which the candidate exceeds the reference. At most one of the two is non-zero. Two accumulators gather these parts separately, and they are added together only once, when the block closes. The unit accepts one row every three cycles, so a block occupies 24 cycles. The accumulators restart by themselves on the first row of each block, so blocks can follow one another with no idle cycles.

Top module: `sad8x8_unit`

## Requirements
- R1: When `sad_valid` is high, `sad_value` equals the sum of |x - y| over the 64 sample pairs of the block just completed. Samples are 16-bit unsigned. Lane j of a row occupies bits [16*j+15 : 16*j] of `x_row` and `y_row`.
- R2: A row is accepted on a rising edge where both `in_valid` and `in_ready` are high. After an accepted row, `in_ready` stays low for exactly two cycles and then returns high. With `in_valid` held high, consecutive rows are therefore accepted three cycles apart.
- R3: When blocks are streamed back to back with `in_valid` held high, results appear once every 24 cycles.
- R4: `sad_valid` is a single-cycle pulse. It rises on the second rising edge after the edge that accepts the eighth row of a block.
- R5: `sad_tag` equals the `in_tag` value that was present when the first row of the same block was accepted.
- R6: Each block's result is independent of every earlier block. The accumulators restart on a block's first row, with no idle cycle needed between blocks.
- R7: Equal samples contribute nothing, so a block compared with an identical block scores 0.
- R8: No overflow occurs at the extremes. All reference samples at 65535 with all candidate samples at 0 scores 4194240, and the reverse case scores the same.
- R9: While `rst_n` is low, `sad_valid` and `in_ready` are low. Row data presented while `in_valid` is low, or while `in_ready` is low, is ignored and does not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Row transfer request |
| in_ready | output | 1 | Unit can take a row on this edge |
| in_tag | input | 4 | Block tag, sampled with the first row |
| x_row | input | 128 | Eight reference samples, lane 0 in the low bits |
| y_row | input | 128 | Eight candidate samples, lane 0 in the low bits |
| sad_valid | output | 1 | One-cycle result strobe |
| sad_value | output | 22 | Block score |
| sad_tag | output | 4 | Tag of the scored block |

## Verification
The situation hardest to reach from the ports is a block whose first row lands in the same accumulator cycle that closes the previous block's last row. The restart must discard the previous totals without losing the new row. Holding `in_valid` high across many random blocks makes this overlap happen at every block boundary. A block at the maximum difference placed directly before an all-zero block exposes any carry-over. Other runs insert random idle gaps and put garbage data on the row bus while `in_valid` is low. These runs confirm that only handshaked rows reach the sums.

// File: rtl/sad_pkg.sv
package sad_pkg;

  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_LANES    = 8;
  localparam int unsigned DEF_ROWS     = 8;
  localparam int unsigned DEF_GAP      = 3;
  localparam int unsigned DEF_TAG_W    = 4;

  // position of a row inside its block
  typedef struct packed {
    logic open;   // first row of a block
    logic close;  // last row of a block
  } row_pos_t;

endpackage

// File: rtl/sad_row_pacer.sv
module sad_row_pacer
  import sad_pkg::*;
#(
  parameter int unsigned ROWS = DEF_ROWS,
  parameter int unsigned GAP  = DEF_GAP
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  output logic     accept,
  output row_pos_t pos
);

  localparam int unsigned ROW_CW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned GAP_CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [ROW_CW-1:0] LAST_ROW = ROW_CW'(ROWS - 1);
  localparam logic [GAP_CW-1:0] GAP_LOAD = GAP_CW'(GAP - 1);

  logic [ROW_CW-1:0] row_q, row_d;
  logic [GAP_CW-1:0] gap_q, gap_d;
  logic              run_q;

  assign in_ready  = run_q && (gap_q == '0);
  assign accept    = in_valid && in_ready;
  assign pos.open  = (row_q == '0);
  assign pos.close = (row_q == LAST_ROW);

  always_comb begin
    row_d = row_q;
    gap_d = gap_q;
    if (accept) begin
      row_d = pos.close ? '0 : row_q + 1'b1;
      gap_d = GAP_LOAD;
    end else if (gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      gap_q <= '0;
      run_q <= 1'b0;
    end else begin
      row_q <= row_d;
      gap_q <= gap_d;
      run_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sad_lane_diff.sv
module sad_lane_diff #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] a_over_b,
  output logic [W-1:0] b_over_a
);

  logic [W:0]   delta;
  logic         borrow;
  logic [W-1:0] ab_d, ba_d;

  always_comb begin
    delta  = {1'b0, a} - {1'b0, b};
    borrow = delta[W];
    ab_d   = borrow ? '0 : delta[W-1:0];
    ba_d   = borrow ? (~delta[W-1:0] + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_over_b <= '0;
      b_over_a <= '0;
    end else if (en) begin
      a_over_b <= ab_d;
      b_over_a <= ba_d;
    end
  end

endmodule

// File: rtl/sad_row_reduce.sv
module sad_row_reduce #(
  parameter int unsigned W     = 16,
  parameter int unsigned LANES = 8,
  parameter int unsigned OUT_W = W + $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [LANES*W-1:0] ab_lanes,
  input  logic [LANES*W-1:0] ba_lanes,
  output logic [OUT_W-1:0]   ab_sum,
  output logic [OUT_W-1:0]   ba_sum
);

  logic [OUT_W-1:0] ab_d, ba_d;

  always_comb begin
    ab_d = '0;
    ba_d = '0;
    for (int j = 0; j < LANES; j++) begin
      ab_d = ab_d + OUT_W'(ab_lanes[j*W +: W]);
      ba_d = ba_d + OUT_W'(ba_lanes[j*W +: W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_sum <= '0;
      ba_sum <= '0;
    end else if (en) begin
      ab_sum <= ab_d;
      ba_sum <= ba_d;
    end
  end

endmodule

// File: rtl/sad_block_accum.sv
module sad_block_accum
  import sad_pkg::*;
#(
  parameter int unsigned ROW_W = 19,
  parameter int unsigned ACC_W = 22,
  parameter int unsigned TAG_W = DEF_TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  row_pos_t         pos,
  input  logic [TAG_W-1:0] tag,
  input  logic [ROW_W-1:0] row_ab,
  input  logic [ROW_W-1:0] row_ba,
  output logic             sad_valid,
  output logic [ACC_W-1:0] sad_value,
  output logic [TAG_W-1:0] sad_tag
);

  logic [ACC_W-1:0] acc_ab_q, acc_ab_d;
  logic [ACC_W-1:0] acc_ba_q, acc_ba_d;
  logic [TAG_W-1:0] blk_tag_q, blk_tag_d;
  logic             out_vld_d;
  logic [ACC_W-1:0] out_val_d;
  logic [TAG_W-1:0] out_tag_d;

  always_comb begin
    acc_ab_d  = (pos.open ? '0 : acc_ab_q) + ACC_W'(row_ab);
    acc_ba_d  = (pos.open ? '0 : acc_ba_q) + ACC_W'(row_ba);
    blk_tag_d = pos.open ? tag : blk_tag_q;
    out_vld_d = en && pos.close;
    out_val_d = acc_ab_d + acc_ba_d;
    out_tag_d = blk_tag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ab_q  <= '0;
      acc_ba_q  <= '0;
      blk_tag_q <= '0;
    end else if (en) begin
      acc_ab_q  <= acc_ab_d;
      acc_ba_q  <= acc_ba_d;
      blk_tag_q <= blk_tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_valid <= 1'b0;
    end else begin
      sad_valid <= out_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_value <= '0;
      sad_tag   <= '0;
    end else if (out_vld_d) begin
      sad_value <= out_val_d;
      sad_tag   <= out_tag_d;
    end
  end

endmodule

// File: rtl/sad8x8_unit.sv
module sad8x8_unit
  import sad_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned LANES    = DEF_LANES,
  parameter int unsigned ROWS     = DEF_ROWS,
  parameter int unsigned GAP      = DEF_GAP,
  parameter int unsigned TAG_W    = DEF_TAG_W,
  localparam int unsigned ROW_W   = SAMPLE_W + $clog2(LANES),
  localparam int unsigned ACC_W   = SAMPLE_W + $clog2(LANES * ROWS),
  localparam int unsigned BUS_W   = LANES * SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [BUS_W-1:0] x_row,
  input  logic [BUS_W-1:0] y_row,
  output logic             sad_valid,
  output logic [ACC_W-1:0] sad_value,
  output logic [TAG_W-1:0] sad_tag
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic     accept;
  row_pos_t acc_pos;

  sad_row_pacer #(
    .ROWS (ROWS),
    .GAP  (GAP)
  ) u_pacer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .pos      (acc_pos)
  );

  // stage 1: per-lane split differences
  logic [BUS_W-1:0] ab_lanes, ba_lanes;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    sad_lane_diff #(.W(SAMPLE_W)) u_diff (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en       (accept),
      .a        (x_row[j*SAMPLE_W +: SAMPLE_W]),
      .b        (y_row[j*SAMPLE_W +: SAMPLE_W]),
      .a_over_b (ab_lanes[j*SAMPLE_W +: SAMPLE_W]),
      .b_over_a (ba_lanes[j*SAMPLE_W +: SAMPLE_W])
    );
  end

  // sideband travelling alongside the data
  logic             s1_vld_q, s2_vld_q;
  row_pos_t         s1_pos_q, s2_pos_q;
  logic [TAG_W-1:0] s1_tag_q, s2_tag_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= accept;
      s2_vld_q <= s1_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_pos_q <= '0;
      s1_tag_q <= '0;
    end else if (accept) begin
      s1_pos_q <= acc_pos;
      s1_tag_q <= in_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_pos_q <= '0;
      s2_tag_q <= '0;
    end else if (s1_vld_q) begin
      s2_pos_q <= s1_pos_q;
      s2_tag_q <= s1_tag_q;
    end
  end

  // stage 2: row totals per direction
  logic [ROW_W-1:0] row_ab, row_ba;

  sad_row_reduce #(
    .W     (SAMPLE_W),
    .LANES (LANES),
    .OUT_W (ROW_W)
  ) u_reduce (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (s1_vld_q),
    .ab_lanes (ab_lanes),
    .ba_lanes (ba_lanes),
    .ab_sum   (row_ab),
    .ba_sum   (row_ba)
  );

  // stage 3: block accumulation and result
  sad_block_accum #(
    .ROW_W (ROW_W),
    .ACC_W (ACC_W),
    .TAG_W (TAG_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (s2_vld_q),
    .pos       (s2_pos_q),
    .tag       (s2_tag_q),
    .row_ab    (row_ab),
    .row_ba    (row_ba),
    .sad_valid (sad_valid),
    .sad_value (sad_value),
    .sad_tag   (sad_tag)
  );

endmodule

// File: rtl/sad8x8_unit_chk.sv
module sad8x8_unit_chk #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned LANES    = 8,
  parameter int unsigned ROWS     = 8,
  parameter int unsigned GAP      = 3,
  parameter int unsigned ACC_W    = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             sad_valid,
  input logic [ACC_W-1:0] sad_value
);

  localparam int unsigned RC_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned SC_W = $clog2(GAP + 1);
  localparam longint unsigned MAX_SAD =
    longint'(LANES) * longint'(ROWS) * ((longint'(1) << SAMPLE_W) - 1);

  logic            take;
  logic [RC_W-1:0] rows_q;
  logic [SC_W-1:0] since_q;
  logic            c1_q, c2_q, c3_q;

  assign take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q  <= '0;
      since_q <= SC_W'(GAP);
      c1_q    <= 1'b0;
      c2_q    <= 1'b0;
      c3_q    <= 1'b0;
    end else begin
      if (take) begin
        rows_q  <= (rows_q == RC_W'(ROWS - 1)) ? '0 : rows_q + 1'b1;
        since_q <= '0;
      end else if (since_q < SC_W'(GAP)) begin
        since_q <= since_q + 1'b1;
      end
      c1_q <= take && (rows_q == RC_W'(ROWS - 1));
      c2_q <= c1_q;
      c3_q <= c2_q;
    end
  end

  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (since_q >= SC_W'(GAP - 1)));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |=> !sad_valid);

  assert_valid_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid == c3_q);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> (longint'(sad_value) <= MAX_SAD));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (!sad_valid && !in_ready));

endmodule

bind sad8x8_unit sad8x8_unit_chk #(
  .SAMPLE_W (SAMPLE_W),
  .LANES    (LANES),
  .ROWS     (ROWS),
  .GAP      (GAP),
  .ACC_W    (ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .sad_valid (sad_valid),
  .sad_value (sad_value)
);

// File: tb/test_sad8x8_unit.sv
module test_sad8x8_unit;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int NL = 8;
  localparam int NR = 8;
  localparam int TW = 4;
  localparam int AW = 22;
  localparam int MAXB = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [TW-1:0]    in_tag = '0;
  logic [NL*SW-1:0] x_row = '0;
  logic [NL*SW-1:0] y_row = '0;
  logic             sad_valid;
  logic [AW-1:0]    sad_value;
  logic [TW-1:0]    sad_tag;

  sad8x8_unit i_sad8x8_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_tag    (in_tag),
    .x_row     (x_row),
    .y_row     (y_row),
    .sad_valid (sad_valid),
    .sad_value (sad_value),
    .sad_tag   (sad_tag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [SW-1:0] bx [64];
  logic [SW-1:0] by [64];

  // expected results queue
  int          exp_val [MAXB];
  int          exp_tag [MAXB];
  int          exp_cyc [MAXB];
  bit          exp_btb [MAXB];
  int          wr_idx = 0;
  int          rd_idx = 0;
  int          last_out_cyc = -1;
  bit          prev_valid = 1'b0;
  int          prev_acc = -100;

  function automatic int ref_sad();
    int s = 0;
    for (int k = 0; k < 64; k++)
      s += (bx[k] > by[k]) ? int'(bx[k]) - int'(by[k]) : int'(by[k]) - int'(bx[k]);
    return s;
  endfunction

  // mode: 0 random, 1 identical, 2 x max / y zero, 3 x zero / y max, 4 small diffs, 5 zeros
  task automatic fill_block(input int mode);
    for (int k = 0; k < 64; k++) begin
      case (mode)
        1: begin bx[k] = SW'($urandom); by[k] = bx[k]; end
        2: begin bx[k] = '1; by[k] = '0; end
        3: begin bx[k] = '0; by[k] = '1; end
        4: begin bx[k] = SW'($urandom); by[k] = bx[k] + SW'($urandom_range(0, 6)) - SW'(3); end
        5: begin bx[k] = '0; by[k] = '0; end
        default: begin bx[k] = SW'($urandom); by[k] = SW'($urandom); end
      endcase
    end
  endtask

  // btb: in_valid kept high, rows expected three cycles apart (R2, R3)
  task automatic send_block(input int tag, input bit btb);
    int acc_cyc = 0;
    exp_val[wr_idx] = ref_sad();
    exp_tag[wr_idx] = tag;
    exp_btb[wr_idx] = btb;
    for (int r = 0; r < NR; r++) begin
      if (!btb) begin
        // garbage with in_valid low must be ignored (R9)
        in_valid = 1'b0;
        x_row = {4{$urandom}};
        y_row = {4{$urandom}};
        in_tag = TW'($urandom);
        repeat ($urandom_range(0, 4)) @(negedge clk);
      end
      for (int j = 0; j < NL; j++) begin
        x_row[j*SW +: SW] = bx[r*NL + j];
        y_row[j*SW +: SW] = by[r*NL + j];
      end
      in_tag = (r == 0) ? TW'(tag) : TW'($urandom);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      acc_cyc = cyc + 1;
      if (btb && (prev_acc >= 0))
        check(acc_cyc - prev_acc == 3, "R2 row spacing", acc_cyc - prev_acc, 3);
      prev_acc = acc_cyc;
      @(negedge clk);
      // garbage while in_ready is low must be ignored (R9)
      x_row = {4{$urandom}};
      y_row = {4{$urandom}};
    end
    exp_cyc[wr_idx] = acc_cyc + 2;
    wr_idx++;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sad_valid) begin
        check(!prev_valid, "R4 single-cycle pulse", 1, 0);
        if (rd_idx < wr_idx) begin
          check(int'(sad_value) == exp_val[rd_idx], "R1/R6/R7/R8 value",
                sad_value, exp_val[rd_idx]);
          check(int'(sad_tag) == exp_tag[rd_idx], "R5 tag", sad_tag, exp_tag[rd_idx]);
          check(cyc == exp_cyc[rd_idx], "R4 latency", cyc, exp_cyc[rd_idx]);
          if (exp_btb[rd_idx] && rd_idx > 0 && exp_btb[rd_idx-1])
            check(cyc - last_out_cyc == 24, "R3 block interval", cyc - last_out_cyc, 24);
          rd_idx++;
        end else begin
          check(1'b0, "R1 unexpected result", sad_value, -1);
        end
        last_out_cyc = cyc;
      end
      prev_valid = sad_valid;
    end
  end

  initial begin
    void'($urandom(32'h5AD1));
    repeat (3) @(negedge clk);
    check(sad_valid == 1'b0, "R9 reset sad_valid", sad_valid, 0);
    check(in_ready == 1'b0, "R9 reset in_ready", in_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R2 ready after reset", in_ready, 1);
    check(sad_valid == 1'b0, "R9 idle no result", sad_valid, 0);

    // directed corners, back to back
    fill_block(1); send_block(1, 1'b1);            // R7 identical -> 0
    fill_block(2); send_block(2, 1'b1);            // R8 max one way
    fill_block(5); send_block(3, 1'b1);            // R6 zeros after max
    fill_block(3); send_block(4, 1'b1);            // R8 max the other way
    fill_block(4); send_block(5, 1'b1);            // mixed small diffs
    // random back-to-back stream (R1, R3, R5, R6)
    for (int b = 0; b < 16; b++) begin
      fill_block(($urandom_range(0, 9) == 0) ? 4 : 0);
      send_block(b & 15, 1'b1);
    end
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    prev_acc = -100;
    // random blocks with idle gaps and garbage (R9)
    for (int b = 0; b < 10; b++) begin
      fill_block(b % 5);
      send_block((b + 7) & 15, 1'b0);
    end
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    check(rd_idx == wr_idx, "R1 all results seen", rd_idx, wr_idx);
    check(exp_val[1] == 4194240 && exp_val[3] == 4194240, "R8 reference bound",
          exp_val[1], 4194240);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule